// File: doc/BRIEF.md
# Page Write Collector with Write Protection

This block sits behind a serial memory-slave protocol engine and gathers the data bytes of one write transaction into a page-sized staging latch. The engine does the bit shifting. It hands this block single-cycle strobes: a START strobe, an address strobe carrying the byte address, and one data strobe per received data byte. The block keeps a per-slot valid flag for every byte of the page. It steps an in-page offset that wraps within the page. For every data byte it returns an acknowledge decision that the engine drives in the ninth bit slot.

The block also samples the external write-protect level across the window from START through the address byte. If that level is seen high at any point in the window, the transaction is marked protected. The data bytes of a protected transaction are then refused and nothing is staged. When the engine signals that a write should be committed (a STOP in the correct slot), the block issues one write pulse to the memory array. The pulse carries the page number, the staged bytes and a byte mask. It is only issued when something was staged and the transaction is not protected.

Top module: `page_wbuf`

## Requirements
- R1: Each accepted data byte is stored in the page slot given by the current offset, and that slot's valid flag is set. On commit, `mem_page_o` carries the upper address bits (addr[7:4] by default), `mem_mask_o` bit k is set for each staged slot k, and `mem_data_o[8k+7:8k]` holds slot k.
- R2: After each accepted or refused data byte, only the low 4 offset bits increment. Past slot 15 the offset returns to slot 0 of the same page, and the page number does not change.
- R3: The transaction is protected if `wp_i` is high in the START cycle, in the address-strobe cycle, or in any cycle between them. A high level on `wp_i` after the address strobe has no effect on the acknowledge of that transaction.
- R4: In a protected transaction, every data byte gets `ack_o`=0, no slot is staged, and a commit produces no write.
- R5: In an unprotected transaction, every data byte that follows the address strobe gets `ack_o`=1. `ack_vld_o` and `ack_o` are valid in the cycle after the data strobe.
- R6: A later byte that wraps onto an already staged slot replaces that slot's value, and the slot stays valid.
- R7: START clears every valid flag, so a commit after a new START and address with no data produces no write.
- R8: A commit produces a single-cycle `mem_we_o` in the cycle after `commit_i`, and only if at least one slot is valid. The commit then clears the flags, so a repeated commit produces no write.
- R9: A data strobe arriving after START but before the address strobe gets `ack_o`=0 and stages nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START seen (one-cycle strobe) |
| wp_i | input | 1 | Write-protect level from the pin |
| addr_stb_i | input | 1 | Address byte complete |
| addr_i | input | ADDR_W | Byte address carried with the address strobe |
| data_stb_i | input | 1 | Data byte complete |
| data_i | input | 8 | Received data byte |
| commit_i | input | 1 | Request to write the staged page |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = NoAck |
| mem_we_o | output | 1 | Memory write pulse |
| mem_page_o | output | ADDR_W-4 | Page number for the write |
| mem_mask_o | output | 16 | Byte enables for the write |
| mem_data_o | output | 128 | Staged page bytes, slot k at bits 8k+7:8k |

## Verification
The bench writes past the page end with 17 bytes. A design that carried the increment into the page bits, or that cleared a slot on overwrite, would show the wrong page, mask or slot-0 value. It raises protect in the START cycle alone, in the address cycle alone, and only after the address. A window that is too narrow would acknowledge protected bytes, and one that is too wide would refuse legal ones. It also issues commits that should be empty: repeated, after a fresh START, and from a protected transaction. A design that keeps stale flags would emit a spurious array write. Finally, it sends a data byte before any address, which a design must not stage.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pwb_prot.sv
module pwb_prot (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wp_i,
  input  logic addr_stb_i,
  output logic prot_o
);
  logic win_q, win_d;
  logic prot_q, prot_d;

  always_comb begin
    win_d  = win_q;
    prot_d = prot_q;
    if (start_i) begin
      win_d  = 1'b1;
      prot_d = wp_i;
    end else if (win_q) begin
      prot_d = prot_q | wp_i;
      if (addr_stb_i) win_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      prot_q <= prot_d;
    end
  end

  assign prot_o = prot_q;

  AST_WP_AT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && addr_stb_i && wp_i && !start_i) |=> prot_o); // R3
  AST_WP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_q && !start_i) |=> $stable(prot_o)); // R3
endmodule

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFF_W  = 4,
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_stb_i,
  output logic              armed_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [PAGE_W-1:0] page_o
);
  logic              armed_q, armed_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [PAGE_W-1:0] page_q, page_d;

  always_comb begin
    armed_d = armed_q;
    off_d   = off_q;
    page_d  = page_q;
    if (start_i) begin
      armed_d = 1'b0;
    end else if (addr_stb_i) begin
      armed_d = 1'b1;
      off_d   = addr_i[OFF_W-1:0];
      page_d  = addr_i[ADDR_W-1:OFF_W];
    end else if (data_stb_i && armed_q) begin
      off_d   = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      off_q   <= '0;
      page_q  <= '0;
    end else begin
      armed_q <= armed_d;
      off_q   <= off_d;
      page_q  <= page_d;
    end
  end

  assign armed_o = armed_q;
  assign off_o   = off_q;
  assign page_o  = page_q;

  AST_OFF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb_i && armed_q && !start_i && !addr_stb_i)
      |=> (off_q == OFF_W'($past(off_q) + 1'b1)) && $stable(page_q)); // R2
endmodule

// File: rtl/pwb_latch.sv
module pwb_latch
  import pwb_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned OFF_W = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [OFF_W-1:0]       wr_off_i,
  input  byte_t                  wr_data_i,
  output logic [SLOTS-1:0]       valid_o,
  output logic [SLOTS*BYTE_W-1:0] data_o
);
  logic [SLOTS-1:0] valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (clr_i) valid_d = '0;
    else if (wr_i) valid_d[wr_off_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    byte_t slot_q;
    logic  slot_en;
    assign slot_en = wr_i && !clr_i && (wr_off_i == OFF_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wr_data_i;
    end
    assign data_o[g*BYTE_W +: BYTE_W] = slot_q;
  end

  assign valid_o = valid_q;

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_o == '0)); // R7
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> ((valid_o & $past(valid_o)) == $past(valid_o))); // R6
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SLOTS  = 16,
  localparam int unsigned OFF_W  = $clog2(SLOTS),
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    wp_i,
  input  logic                    addr_stb_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    data_stb_i,
  input  logic [7:0]              data_i,
  input  logic                    commit_i,
  output logic                    ack_vld_o,
  output logic                    ack_o,
  output logic                    mem_we_o,
  output logic [PAGE_W-1:0]       mem_page_o,
  output logic [SLOTS-1:0]        mem_mask_o,
  output logic [SLOTS*BYTE_W-1:0] mem_data_o
);
  logic              prot;
  logic              armed;
  logic [OFF_W-1:0]  off;
  logic [PAGE_W-1:0] page;
  logic [SLOTS-1:0]  valid;
  logic              take, fire, clr;

  pwb_prot u_prot (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wp_i(wp_i),
    .addr_stb_i(addr_stb_i), .prot_o(prot)
  );

  pwb_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_stb_i(addr_stb_i),
    .addr_i(addr_i), .data_stb_i(data_stb_i), .armed_o(armed),
    .off_o(off), .page_o(page)
  );

  assign take = data_stb_i && armed && !prot && !start_i && !addr_stb_i;
  assign fire = commit_i && armed && !prot && !start_i && (|valid);
  assign clr  = start_i || fire;

  pwb_latch #(.SLOTS(SLOTS)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_i(take), .wr_off_i(off),
    .wr_data_i(data_i), .valid_o(valid), .data_o(mem_data_o)
  );

  logic              ack_vld_q, ack_vld_d, ack_q, ack_d;
  logic              we_q, we_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [SLOTS-1:0]  mask_q, mask_d;

  always_comb begin
    ack_vld_d = data_stb_i && !start_i && !addr_stb_i;
    ack_d     = take;
    we_d      = fire;
    page_d    = page_q;
    mask_d    = mask_q;
    if (fire) begin
      page_d = page;
      mask_d = valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
      we_q      <= 1'b0;
      page_q    <= '0;
      mask_q    <= '0;
    end else begin
      ack_vld_q <= ack_vld_d;
      ack_q     <= ack_d;
      we_q      <= we_d;
      page_q    <= page_d;
      mask_q    <= mask_d;
    end
  end

  assign ack_vld_o  = ack_vld_q;
  assign ack_o      = ack_q;
  assign mem_we_o   = we_q;
  assign mem_page_o = page_q;
  assign mem_mask_o = mask_q;

  AST_WE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_mask_o != '0)); // R8
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o); // R8
  AST_PROT_NOSTAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb_i && prot && !start_i && !commit_i) |=> $stable(valid)); // R4
  AST_ACK_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ack_vld_o); // R9
endmodule

// File: tb/sim_page_wbuf.sv
module sim_page_wbuf;
  logic         clk, rst_n;
  logic         start_i, wp_i, addr_stb_i, data_stb_i, commit_i;
  logic [7:0]   addr_i, data_i;
  logic         ack_vld_o, ack_o, mem_we_o;
  logic [3:0]   mem_page_o;
  logic [15:0]  mem_mask_o;
  logic [127:0] mem_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  page_wbuf u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wp_i(wp_i),
    .addr_stb_i(addr_stb_i), .addr_i(addr_i), .data_stb_i(data_stb_i),
    .data_i(data_i), .commit_i(commit_i), .ack_vld_o(ack_vld_o),
    .ack_o(ack_o), .mem_we_o(mem_we_o), .mem_page_o(mem_page_o),
    .mem_mask_o(mem_mask_o), .mem_data_o(mem_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // st wc as addr ds data cm | eav ea ewe epage emask
  function automatic logic [43:0] mk(input logic st, input logic wc,
      input logic as_, input logic [7:0] a, input logic ds,
      input logic [7:0] d, input logic cm, input logic eav,
      input logic ea, input logic ewe, input logic [3:0] ep,
      input logic [15:0] em);
    return {st, wc, as_, a, ds, d, cm, eav, ea, ewe, ep, em};
  endfunction

  localparam int NV = 26;
  localparam logic [43:0] VEC [NV] = '{
    mk(1,0,0,8'h00,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,0,1,8'h3D,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,0,0,8'h00,1,8'h11,0, 1,1,0,4'h0,16'h0000), // R5
    mk(0,0,0,8'h00,1,8'h22,0, 1,1,0,4'h0,16'h0000),
    mk(0,0,0,8'h00,1,8'h33,0, 1,1,0,4'h0,16'h0000),
    mk(0,0,0,8'h00,1,8'h44,0, 1,1,0,4'h0,16'h0000), // R2 wrap
    mk(0,0,0,8'h00,0,8'h00,1, 0,0,1,4'h3,16'hE001), // R1 R2
    mk(0,0,0,8'h00,0,8'h00,1, 0,0,0,4'h0,16'h0000), // R8 repeat
    mk(1,0,0,8'h00,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,1,1,8'h50,0,8'h00,0, 0,0,0,4'h0,16'h0000), // R3 addr cycle
    mk(0,0,0,8'h00,1,8'h55,0, 1,0,0,4'h0,16'h0000), // R4
    mk(0,0,0,8'h00,0,8'h00,1, 0,0,0,4'h0,16'h0000), // R4
    mk(1,0,0,8'h00,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,0,0,8'h00,1,8'h66,0, 1,0,0,4'h0,16'h0000), // R9
    mk(0,0,1,8'h72,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,1,0,8'h00,1,8'h77,0, 1,1,0,4'h0,16'h0000), // R3 late wp
    mk(0,0,0,8'h00,0,8'h00,1, 0,0,1,4'h7,16'h0004), // R9 R1
    mk(1,1,0,8'h00,0,8'h00,0, 0,0,0,4'h0,16'h0000), // R3 start cycle
    mk(0,0,1,8'h10,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,0,0,8'h00,1,8'h88,0, 1,0,0,4'h0,16'h0000), // R3 R4
    mk(1,0,0,8'h00,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,0,1,8'h20,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,0,0,8'h00,1,8'h99,0, 1,1,0,4'h0,16'h0000),
    mk(1,0,0,8'h00,0,8'h00,0, 0,0,0,4'h0,16'h0000), // R7
    mk(0,0,1,8'h30,0,8'h00,0, 0,0,0,4'h0,16'h0000),
    mk(0,0,0,8'h00,0,8'h00,1, 0,0,0,4'h0,16'h0000)  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    start_i = 0; wp_i = 0; addr_stb_i = 0; addr_i = 0;
    data_stb_i = 0; data_i = 0; commit_i = 0;
  endtask

  // drive one cycle at the falling edge, return at the next falling edge
  task automatic cyc(input logic st, input logic wc, input logic as_,
      input logic [7:0] a, input logic ds, input logic [7:0] d, input logic cm);
    start_i = st; wp_i = wc; addr_stb_i = as_; addr_i = a;
    data_stb_i = ds; data_i = d; commit_i = cm;
    @(negedge clk);
    idle_in();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset we", {31'd0, mem_we_o}, 0);
    chk("R5 reset ack", {30'd0, ack_vld_o, ack_o}, 0);
    chk("R1 reset mask", {16'd0, mem_mask_o}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      cyc(v[43], v[42], v[41], v[40:33], v[32], v[31:24], v[23]);
      chk($sformatf("R1-vec%0d ack_vld", i), {31'd0, ack_vld_o}, {31'd0, v[22]});
      chk($sformatf("R5 vec%0d ack", i), {31'd0, ack_o}, {31'd0, v[21]});
      chk($sformatf("R8 vec%0d we", i), {31'd0, mem_we_o}, {31'd0, v[20]});
      if (v[20]) begin
        chk($sformatf("R1 vec%0d page", i), {28'd0, mem_page_o}, {28'd0, v[19:16]});
        chk($sformatf("R1 vec%0d mask", i), {16'd0, mem_mask_o}, {16'd0, v[15:0]});
      end
    end

    // R6: 17 bytes from slot 0 of page A: the last one lands on slot 0
    cyc(1, 0, 0, 8'h00, 0, 8'h00, 0);
    cyc(0, 0, 1, 8'hA0, 0, 8'h00, 0);
    for (int k = 0; k < 17; k++) cyc(0, 0, 0, 8'h00, 1, 8'(k + 1), 0);
    cyc(0, 0, 0, 8'h00, 0, 8'h00, 1);
    chk("R8 full commit we", {31'd0, mem_we_o}, 1);
    chk("R2 full page", {28'd0, mem_page_o}, 32'hA);
    chk("R6 full mask", {16'd0, mem_mask_o}, 32'hFFFF);
    chk("R6 slot0 overwritten", {24'd0, mem_data_o[7:0]}, 32'd17);
    chk("R1 slot5", {24'd0, mem_data_o[47:40]}, 32'd6);
    chk("R1 slot15", {24'd0, mem_data_o[127:120]}, 32'd16);

    // R1: single byte at slot 9
    cyc(1, 0, 0, 8'h00, 0, 8'h00, 0);
    cyc(0, 0, 1, 8'h59, 0, 8'h00, 0);
    cyc(0, 0, 0, 8'h00, 1, 8'hC3, 0);
    cyc(0, 0, 0, 8'h00, 0, 8'h00, 1);
    chk("R1 byte write mask", {16'd0, mem_mask_o}, 32'h0200);
    chk("R1 byte write data", {24'd0, mem_data_o[79:72]}, 32'hC3);
    chk("R1 byte write page", {28'd0, mem_page_o}, 32'h5);

    // reset in mid-transaction empties the buffer
    cyc(1, 0, 0, 8'h00, 0, 8'h00, 0);
    cyc(0, 0, 1, 8'h00, 0, 8'h00, 0);
    cyc(0, 0, 0, 8'h00, 1, 8'h5A, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 0, 8'h00, 0, 8'h00, 1);
    chk("R8 commit after reset", {31'd0, mem_we_o}, 0);

    finish_run();
  end
endmodule